// File: doc/BRIEF.md
# Dual Compare-Match Timer Channel Pair

The block holds two byte-wide up-counters. Each counter has two compare registers, A and B. A counter moves only when a one-cycle count strobe arrives from a clock-select block that sits outside this block. A strobe that finds the counter already equal to a compare value declares a match for that compare. Each match drives an action on the channel's output pin. Each match also raises an interrupt pulse on the next clock cycle. Compare A also raises a conversion-start pulse. A wrap from all ones to zero raises an overflow pulse. The counter can be cleared by compare A or by compare B. It can also be cleared by an external reset input, which either holds the counter at zero while high or clears it on a rising edge. Together these give free-running pulse trains, PWM and inactivity watchdogs.

Software reaches the registers through a plain write port and a combinational read port. These are control ports with no back-pressure: a write takes effect on the clock edge where `wr_en` is high, and a read returns the value held at that moment. Setting the cascade bit in channel 0 joins the two counters into one 16-bit counter. Channel 0 holds the upper byte, and the pair uses channel 0's strobe, control, pin and pulses.

Top module: `cmtimer_pair`

## Requirements
- R1: After reset every counter reads 0, every compare register reads all ones, control and action registers read 0, and the pin and all pulse outputs are low.
- R2: Register addresses per channel: 0 counter, 1 compare A, 2 compare B, 3 control, 4 action. Control bit 0 is the enable. While it is 0, the counter holds its value and writes to addresses 0, 1, 2 and 4 are ignored. The control register itself can always be written.
- R3: An enabled counter adds one on each cycle in which its strobe is high. A step from all ones to zero raises `irq_ovf` for the single cycle in which the counter reads zero.
- R4: A strobe while the counter equals compare A is a match. `irq_cma` and `conv_start` go high for one cycle in the following cycle. With clear on A, a match returns the counter to 0, so the match period is compare A plus one strobes.
- R5: Control bits 2:1 select the clear source: 0 none, 1 compare A, 2 compare B, 3 external input. Compare B matches pulse `irq_cmb` with the same timing as R4.
- R6: With external clear and control bit 3 at 0, the counter is held at 0 on every cycle in which `ext_rst` is high.
- R7: With external clear and control bit 3 at 1, the counter clears only on a rising edge of `ext_rst`, relative to its value at the previous clock. It counts normally while the input stays high.
- R8: A counter write in the same cycle as any clear is ignored and the counter becomes 0. A counter write in the same cycle as a strobe loads the written value, and the increment is dropped.
- R9: A write to a compare register in the same cycle as its match suppresses that match: no pulse, no clear and no pin action. The new value is used from then on.
- R10: Action register bits 1:0 give the compare A action and bits 3:2 the compare B action: 0 no change, 1 drive low, 2 drive high, 3 toggle. The pin updates in the cycle after the match. If both match together, only the higher action applies, in the order toggle, high, low, none.
- R11: Control bit 4 of channel 0 cascades the channels. Channel 0 is the upper byte of the counter and of both compare values. The low byte counts on `cnt_stb[0]`, and the upper byte advances only on a low-byte wrap. Matches use all 16 bits. Pin and pulses appear on channel 0 only, `cnt_stb[1]` is ignored, and a 0xFFFF wrap raises `irq_ovf[0]`.
- R12: `rd_data` returns the addressed register of the selected channel combinationally, zero-extended. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 1 | Channel selected for the write |
| wr_addr | input | 3 | Register address for the write |
| wr_data | input | W | Write data |
| rd_ch | input | 1 | Channel selected for the read |
| rd_addr | input | 3 | Register address for the read |
| rd_data | output | W | Read data |
| cnt_stb | input | 2 | Count strobes, one per channel |
| ext_rst | input | 2 | External clear inputs, one per channel |
| tmr_out | output | 2 | Compare-driven output pins |
| irq_cma | output | 2 | Compare A match pulses |
| irq_cmb | output | 2 | Compare B match pulses |
| irq_ovf | output | 2 | Overflow pulses |
| conv_start | output | 2 | Conversion-start pulses from compare A |

## Verification
The bench targets the same-cycle races. It checks a counter write against a clear and against a strobe, and a compare write against its own match. A design with the wrong priorities would keep the written count, or fire a pulse that should have been cancelled. A walk over action pairs with both compares equal exposes any priority order other than toggle, high, low, none: the pin would settle at the wrong level. Both external-clear modes are tested while the input stays high. A level/edge mix-up shows up as a counter that either keeps counting or freezes. The cascaded walk across the low-byte wrap and up to 0x0102 and 0xFFFF catches an upper byte that steps on every strobe, matches taken on one byte only, and pulses leaking onto channel 1.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    CLR_NONE = 2'd0,
    CLR_CMA  = 2'd1,
    CLR_CMB  = 2'd2,
    CLR_EXT  = 2'd3
  } clr_e;

  typedef enum logic [2:0] {
    RA_CNT  = 3'd0,
    RA_CMPA = 3'd1,
    RA_CMPB = 3'd2,
    RA_CTRL = 3'd3,
    RA_ACT  = 3'd4
  } reg_e;

  localparam int CTRL_W = 5;
  localparam int ACT_W  = 4;

  // Numeric code order equals priority order, so the larger code wins.
  function automatic act_e act_pick(input logic ma, input logic mb,
                                    input act_e a, input act_e b);
    if (ma && mb) return (a > b) ? a : b;
    if (ma) return a;
    if (mb) return b;
    return ACT_NONE;
  endfunction

  function automatic logic pin_next(input logic cur, input act_e a);
    case (a)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/cmt_byte_cnt.sv
module cmt_byte_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  // Priority: frozen when disabled, then clear, then load, then step.
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (en) begin
      if (clr)      cnt <= '0;
      else if (ld)  cnt <= ld_val;
      else if (inc) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cmt_out_ctl.sv
module cmt_out_ctl
  import cmt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ma,
  input  logic mb,
  input  act_e act_a,
  input  act_e act_b,
  input  logic wrap,
  output logic pin,
  output logic irq_a,
  output logic irq_b,
  output logic irq_ovf,
  output logic conv
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin     <= 1'b0;
      irq_a   <= 1'b0;
      irq_b   <= 1'b0;
      irq_ovf <= 1'b0;
      conv    <= 1'b0;
    end else begin
      pin     <= pin_next(pin, act_pick(ma, mb, act_a, act_b));
      irq_a   <= ma;
      irq_b   <= mb;
      irq_ovf <= wrap;
      conv    <= ma;
    end
  end
endmodule

// File: rtl/cmtimer_pair.sv
module cmtimer_pair
  import cmt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_ch,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         rd_ch,
  input  logic [2:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic [1:0]   cnt_stb,
  input  logic [1:0]   ext_rst,
  output logic [1:0]   tmr_out,
  output logic [1:0]   irq_cma,
  output logic [1:0]   irq_cmb,
  output logic [1:0]   irq_ovf,
  output logic [1:0]   conv_start
);
  localparam int NCH = 2;
  localparam logic [W-1:0] ALL1 = '1;

  logic [NCH-1:0][W-1:0]      cnt_q, cmpa_q, cmpb_q;
  logic [NCH-1:0][CTRL_W-1:0] ctrl_q;
  logic [NCH-1:0][ACT_W-1:0]  act_q;
  logic [NCH-1:0] ext_q, en_eff, wc, wa, wb, wt, wx, eqa, eqb, xclr;
  logic [NCH-1:0] tick, ma, mb, clr, inc, wrap;
  logic           casc;

  assign casc = ctrl_q[0][4];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    clr_e sel;

    if (g == 0) begin : g_en0
      assign en_eff[g] = ctrl_q[0][0];
    end else begin : g_enx
      assign en_eff[g] = casc ? ctrl_q[0][0] : ctrl_q[g][0];
    end

    assign hit   = wr_en && (wr_ch == 1'(g));
    assign wc[g] = hit && (wr_addr == RA_CNT)  && en_eff[g];
    assign wa[g] = hit && (wr_addr == RA_CMPA) && en_eff[g];
    assign wb[g] = hit && (wr_addr == RA_CMPB) && en_eff[g];
    assign wx[g] = hit && (wr_addr == RA_ACT)  && en_eff[g];
    assign wt[g] = hit && (wr_addr == RA_CTRL);

    assign sel     = clr_e'(ctrl_q[g][2:1]);
    assign eqa[g]  = (cnt_q[g] == cmpa_q[g]);
    assign eqb[g]  = (cnt_q[g] == cmpb_q[g]);
    assign xclr[g] = (sel == CLR_EXT) &&
                     (ctrl_q[g][3] ? (ext_rst[g] && !ext_q[g]) : ext_rst[g]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ext_q[g]  <= 1'b0;
        cmpa_q[g] <= ALL1;
        cmpb_q[g] <= ALL1;
        ctrl_q[g] <= '0;
        act_q[g]  <= '0;
      end else begin
        ext_q[g] <= ext_rst[g];
        if (wa[g]) cmpa_q[g] <= wr_data;
        if (wb[g]) cmpb_q[g] <= wr_data;
        if (wt[g]) ctrl_q[g] <= wr_data[CTRL_W-1:0];
        if (wx[g]) act_q[g]  <= wr_data[ACT_W-1:0];
      end
    end

    cmt_byte_cnt #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(en_eff[g]), .clr(clr[g]),
      .ld(wc[g]), .ld_val(wr_data), .inc(inc[g]), .cnt(cnt_q[g])
    );

    cmt_out_ctl u_out (
      .clk(clk), .rst_n(rst_n), .ma(ma[g]), .mb(mb[g]),
      .act_a(act_e'(act_q[g][1:0])), .act_b(act_e'(act_q[g][3:2])),
      .wrap(wrap[g]), .pin(tmr_out[g]), .irq_a(irq_cma[g]),
      .irq_b(irq_cmb[g]), .irq_ovf(irq_ovf[g]), .conv(conv_start[g])
    );
  end

  // Event resolution: per channel, then overridden for the cascaded pair.
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      tick[i] = cnt_stb[i] && en_eff[i];
      ma[i]   = tick[i] && eqa[i] && !wa[i];
      mb[i]   = tick[i] && eqb[i] && !wb[i];
      clr[i]  = ((clr_e'(ctrl_q[i][2:1]) == CLR_CMA) && ma[i]) ||
                ((clr_e'(ctrl_q[i][2:1]) == CLR_CMB) && mb[i]) || xclr[i];
      inc[i]  = tick[i];
      wrap[i] = tick[i] && (cnt_q[i] == ALL1) && !wc[i] && !clr[i];
    end
    if (casc) begin
      tick[1] = 1'b0;
      ma[0]   = tick[0] && eqa[0] && eqa[1] && !wa[0] && !wa[1];
      mb[0]   = tick[0] && eqb[0] && eqb[1] && !wb[0] && !wb[1];
      ma[1]   = 1'b0;
      mb[1]   = 1'b0;
      clr[0]  = ((clr_e'(ctrl_q[0][2:1]) == CLR_CMA) && ma[0]) ||
                ((clr_e'(ctrl_q[0][2:1]) == CLR_CMB) && mb[0]) || xclr[0];
      clr[1]  = clr[0];
      inc[1]  = tick[0] && !wc[0] && !wc[1];
      inc[0]  = inc[1] && (cnt_q[1] == ALL1);
      wrap[0] = inc[0] && (cnt_q[0] == ALL1) && !clr[0];
      wrap[1] = 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      RA_CNT:  rd_data = cnt_q[rd_ch];
      RA_CMPA: rd_data = cmpa_q[rd_ch];
      RA_CMPB: rd_data = cmpb_q[rd_ch];
      RA_CTRL: rd_data = W'(ctrl_q[rd_ch]);
      RA_ACT:  rd_data = W'(act_q[rd_ch]);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cmt_chk.sv
module cmt_chk #(
  parameter int W  = 8,
  parameter int CW = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         cnt_stb,
  input logic [1:0]         ext_rst,
  input logic [1:0]         irq_cma,
  input logic [1:0]         irq_cmb,
  input logic [1:0]         irq_ovf,
  input logic [1:0][W-1:0]  cnt_q,
  input logic [1:0][CW-1:0] ctrl_q
);
  assert_cma0_after_stb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cma[0] |-> $past(cnt_stb[0]));
  assert_cma1_after_stb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cma[1] |-> $past(cnt_stb[1]));
  assert_ovf0_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf[0] |-> (cnt_q[0] == '0));
  assert_ovf1_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf[1] |-> (cnt_q[1] == '0));
  assert_level_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0][0] && ctrl_q[0][2:1] == 2'd3 && !ctrl_q[0][3] && ext_rst[0])
      |=> (cnt_q[0] == '0));
  assert_disabled_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0][0] |=> $stable(cnt_q[0]));
  assert_casc_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_q[0][4]) |-> (!irq_cma[1] && !irq_cmb[1] && !irq_ovf[1]));
endmodule

bind cmtimer_pair cmt_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_stb(cnt_stb), .ext_rst(ext_rst),
  .irq_cma(irq_cma), .irq_cmb(irq_cmb), .irq_ovf(irq_ovf),
  .cnt_q(cnt_q), .ctrl_q(ctrl_q)
);

// File: tb/cmtimer_pair_tb.sv
module cmtimer_pair_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, wr_ch = 1'b0, rd_ch = 1'b0;
  logic [2:0]   wr_addr = '0, rd_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic [1:0]   cnt_stb = '0, ext_rst = '0;
  logic [1:0]   tmr_out, irq_cma, irq_cmb, irq_ovf, conv_start;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmtimer_pair #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_ch(rd_ch), .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt_stb(cnt_stb), .ext_rst(ext_rst), .tmr_out(tmr_out), .irq_cma(irq_cma),
    .irq_cmb(irq_cmb), .irq_ovf(irq_ovf), .conv_start(conv_start)
  );

  // Action pair walk for R10: {action A, action B, winning action}.
  localparam logic [5:0] VEC [10] = '{
    {2'd2, 2'd0, 2'd2}, {2'd1, 2'd0, 2'd1}, {2'd3, 2'd0, 2'd3},
    {2'd3, 2'd1, 2'd3}, {2'd1, 2'd2, 2'd2}, {2'd2, 2'd3, 2'd3},
    {2'd0, 2'd1, 2'd1}, {2'd1, 2'd1, 2'd1}, {2'd0, 2'd0, 2'd0},
    {2'd2, 2'd1, 2'd2}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic ch, input logic [2:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_ch = ch; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic stb(input int ch);
    cnt_stb[ch] = 1'b1;
    @(negedge clk);
    cnt_stb = '0;
  endtask

  task automatic wr_stb(input logic ch, input logic [2:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_ch = ch; wr_addr = a; wr_data = d;
    cnt_stb[ch] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cnt_stb = '0;
  endtask

  task automatic rd(input logic ch, input logic [2:0] a, output int v);
    rd_ch = ch; rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    logic pin_m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, 3'd0, v); chk("R1 cnt0", v, 0);
    rd(1, 3'd1, v); chk("R1 cmpa1", v, 8'hFF);
    rd(0, 3'd2, v); chk("R1 cmpb0", v, 8'hFF);
    rd(0, 3'd3, v); chk("R1 ctrl0", v, 0);
    chk("R1 outputs", int'({tmr_out, irq_cma, irq_cmb, irq_ovf, conv_start}), 0);

    // R2 disabled channel ignores writes and strobes
    wr(0, 3'd0, 8'h07); rd(0, 3'd0, v); chk("R2 cnt write ignored", v, 0);
    wr(0, 3'd1, 8'h33); rd(0, 3'd1, v); chk("R2 cmpa write ignored", v, 8'hFF);
    stb(0); rd(0, 3'd0, v); chk("R2 frozen", v, 0);
    wr(0, 3'd3, 8'h01); rd(0, 3'd3, v); chk("R2 ctrl writable", v, 1);

    // R3 counting and overflow pulse
    wr(0, 3'd0, 8'hFE);
    stb(0); rd(0, 3'd0, v); chk("R3 step", v, 8'hFF);
    chk("R3 no ovf early", int'(irq_ovf[0]), 0);
    stb(0); rd(0, 3'd0, v); chk("R3 wrap", v, 0);
    chk("R3 ovf pulse", int'(irq_ovf[0]), 1);
    @(negedge clk); chk("R3 ovf one cycle", int'(irq_ovf[0]), 0);

    // R4 clear on compare A, period cmpa+1
    wr(0, 3'd3, 8'h03); wr(0, 3'd1, 8'h03); wr(0, 3'd0, 8'h00);
    for (int k = 0; k < 4; k++) begin
      stb(0);
      rd(0, 3'd0, v);
      chk("R4 count", v, (k == 3) ? 0 : k + 1);
      chk("R4 irq_cma", int'(irq_cma[0]), (k == 3) ? 1 : 0);
      chk("R4 conv_start", int'(conv_start[0]), (k == 3) ? 1 : 0);
    end

    // R5 clear on compare B
    wr(0, 3'd3, 8'h05); wr(0, 3'd1, 8'hFF); wr(0, 3'd2, 8'h01); wr(0, 3'd0, 8'h00);
    stb(0); chk("R5 no match yet", int'(irq_cmb[0]), 0);
    stb(0); rd(0, 3'd0, v); chk("R5 cleared by B", v, 0);
    chk("R5 irq_cmb", int'(irq_cmb[0]), 1);
    chk("R5 irq_cma quiet", int'(irq_cma[0]), 0);

    // R6 level hold, with R8 write-vs-clear
    wr(0, 3'd3, 8'h07); wr(0, 3'd0, 8'h09);
    ext_rst[0] = 1'b1; @(negedge clk);
    rd(0, 3'd0, v); chk("R6 held at zero", v, 0);
    wr(0, 3'd0, 8'h20); rd(0, 3'd0, v); chk("R8 write loses to ext clear", v, 0);
    stb(0); rd(0, 3'd0, v); chk("R6 strobe held", v, 0);
    ext_rst[0] = 1'b0;
    stb(0); stb(0); rd(0, 3'd0, v); chk("R6 counts after release", v, 2);

    // R7 rising-edge clear
    wr(0, 3'd3, 8'h0F);
    ext_rst[0] = 1'b1; @(negedge clk);
    rd(0, 3'd0, v); chk("R7 edge clears", v, 0);
    stb(0); stb(0); rd(0, 3'd0, v); chk("R7 counts while high", v, 2);
    ext_rst[0] = 1'b0; @(negedge clk);
    rd(0, 3'd0, v); chk("R7 falling no effect", v, 2);

    // R8 write racing compare clear and strobe
    wr(0, 3'd3, 8'h03); wr(0, 3'd1, 8'h04); wr(0, 3'd0, 8'h04);
    wr_stb(0, 3'd0, 8'h09); rd(0, 3'd0, v); chk("R8 clear beats write", v, 0);
    chk("R8 match still fires", int'(irq_cma[0]), 1);
    wr(0, 3'd3, 8'h01); wr(0, 3'd0, 8'h03);
    wr_stb(0, 3'd0, 8'h20); rd(0, 3'd0, v); chk("R8 write beats step", v, 8'h20);

    // R9 compare write racing its match
    wr(0, 3'd3, 8'h03); wr(0, 3'd1, 8'h06); wr(0, 3'd0, 8'h06);
    wr_stb(0, 3'd1, 8'h0A);
    chk("R9 match suppressed", int'(irq_cma[0]), 0);
    rd(0, 3'd0, v); chk("R9 no clear", v, 7);
    rd(0, 3'd1, v); chk("R9 new compare", v, 8'h0A);
    stb(0); stb(0); stb(0); stb(0);
    rd(0, 3'd0, v); chk("R9 new value matches", v, 0);
    chk("R9 new value irq", int'(irq_cma[0]), 1);

    // R10 table walk on channel 1, both compares equal
    wr(1, 3'd3, 8'h01); wr(1, 3'd1, 8'h05); wr(1, 3'd2, 8'h05);
    pin_m = 1'b0;
    for (int i = 0; i < 10; i++) begin
      wr(1, 3'd4, {4'd0, VEC[i][3:2], VEC[i][5:4]});
      wr(1, 3'd0, 8'h05);
      stb(1);
      case (VEC[i][1:0])
        2'd1: pin_m = 1'b0;
        2'd2: pin_m = 1'b1;
        2'd3: pin_m = ~pin_m;
        default: pin_m = pin_m;
      endcase
      chk("R10 pin priority", int'(tmr_out[1]), int'(pin_m));
      chk("R10 both pulses", int'({irq_cma[1], irq_cmb[1]}), 3);
    end

    // R11 cascade
    wr(0, 3'd3, 8'h13);
    wr(0, 3'd1, 8'h01); wr(1, 3'd1, 8'h02);
    wr(0, 3'd2, 8'hFF); wr(1, 3'd2, 8'hFF);
    wr(0, 3'd4, 8'h03);
    wr(0, 3'd0, 8'h00); wr(1, 3'd0, 8'hFE);
    stb(0); rd(1, 3'd0, v); chk("R11 low step", v, 8'hFF);
    rd(0, 3'd0, v); chk("R11 high holds", v, 0);
    stb(0); rd(1, 3'd0, v); chk("R11 low wraps", v, 0);
    rd(0, 3'd0, v); chk("R11 high carries", v, 1);
    chk("R11 no ch1 ovf", int'(irq_ovf[1]), 0);
    stb(1); rd(1, 3'd0, v); chk("R11 ch1 strobe ignored", v, 0);
    wr(1, 3'd0, 8'h02);
    stb(0);
    chk("R11 16-bit match", int'(irq_cma[0]), 1);
    chk("R11 ch1 quiet", int'(irq_cma[1]), 0);
    chk("R11 ch0 pin toggled", int'(tmr_out[0]), 1);
    rd(0, 3'd0, v); chk("R11 high cleared", v, 0);
    rd(1, 3'd0, v); chk("R11 low cleared", v, 0);
    wr(0, 3'd0, 8'hFF); wr(1, 3'd0, 8'hFF);
    stb(0); chk("R11 16-bit overflow", int'(irq_ovf[0]), 1);
    rd(0, 3'd0, v); chk("R11 wrap high", v, 0);

    // R12 read port
    rd(0, 3'd7, v); chk("R12 unmapped", v, 0);
    rd(0, 3'd3, v); chk("R12 ctrl read", v, 8'h13);
    rd(1, 3'd4, v); chk("R12 act read", v, 8'h06);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule